// File: doc/BRIEF.md
# Cyclic Preset Counter with Wrap Width

This block is a cyclic up/down counter. Its count pulses come already decoded from a pulse-input stage. It holds two programmable values. The first is a coincidence point, which sets a latched flag when the count lands on it. The second is a count width: when the running value climbs to the width it falls back to zero on its own and starts again. Every wrap, in either direction, raises a one-cycle pulse. That pulse is aligned with the cycle in which the value shows its new position.

A host writes the two values through a shared load bus and one strobe per value. An initial-setting strobe puts both values back to their default of 100 and clears the count and the flag. A software clear and an external clear are ORed together. Either one holds the value at zero for as long as it is asserted. The coincidence flag stays on until output disable is asserted. While output disable stays high, the flag cannot be set again.

Top module: `cyc_counter`

## Requirements
- R1: After asynchronous reset, value_o, coin_o and wrap_o are 0, and the coincidence point and the width are both 100.
- R2: With cnt_en_i high and exactly one of cnt_up_i or cnt_dn_i high at a clock edge, the value moves by one. When cnt_en_i is low, or both pulses are high together, the value does not change.
- R3: On an up step whose incremented value is at or above the width, value_o becomes 0. In that same cycle wrap_o is 1, and it is 1 for that one cycle only.
- R4: On a down step from 0 with a non-zero width, value_o becomes width-1 and wrap_o is 1 for that cycle. A down step from any other value decrements it.
- R5: With a width of 0, count pulses are ignored: value_o holds, wrap_o stays 0 and coin_o is not set.
- R6: While sw_clr_i or ext_clr_i is high, value_o is 0 from the next cycle and count pulses are ignored. coin_o is left as it was.
- R7: coin_o becomes 1 when a count step produces a value equal to the coincidence point. On an up step this is the value before the wrap, so a point equal to the width is met. coin_o then stays 1.
- R8: While out_dis_i is high, coin_o is 0 from the next cycle, and a coincidence during that time does not set it.
- R9: A high pt_load_i or wid_load_i loads load_val_i into the coincidence point or the width. A value above MAX_VAL (999999 by default) is replaced by MAX_VAL. A load does not change value_o.
- R10: A high init_i restores both programmable values to 100 and clears value_o and coin_o. It takes priority over clears, loads and counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initial-setting strobe |
| cnt_en_i | input | 1 | Count enable |
| cnt_up_i | input | 1 | Decoded up-count pulse |
| cnt_dn_i | input | 1 | Decoded down-count pulse |
| sw_clr_i | input | 1 | Software clear of the value |
| ext_clr_i | input | 1 | External clear of the value |
| pt_load_i | input | 1 | Load strobe for the coincidence point |
| wid_load_i | input | 1 | Load strobe for the width |
| load_val_i | input | VAL_W (20) | Value for either load strobe |
| out_dis_i | input | 1 | Output disable; clears and blocks the coincidence flag |
| value_o | output | VAL_W (20) | Current count value |
| coin_o | output | 1 | Latched coincidence flag |
| wrap_o | output | 1 | One-cycle pulse on a wrap in either direction |

## Verification
The assertions take all inputs to be synchronous to clk_i and held stable around its rising edge. They also take the width and the coincidence point to be reachable only through the clamped load path. They assume nothing about whether up and down pulses are mutually exclusive: the simultaneous case is legal, and it is checked as a no-step. The stimulus changes every input on the falling edge only. It sweeps small widths and points, where the expected values follow from modular arithmetic. To reach the clamp boundary, it steps down from zero instead of counting up a million times.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned r;
    r = 1;
    while ((64'd1 << r) <= v) r++;
    return r;
  endfunction

endpackage

// File: rtl/cyc_step_dec.sv
module cyc_step_dec
  import cyc_pkg::*;
(
  input  logic  en_i,
  input  logic  up_i,
  input  logic  dn_i,
  output step_e step_o
);
  always_comb begin
    step_o = STEP_NONE;
    if (en_i && (up_i ^ dn_i)) step_o = up_i ? STEP_UP : STEP_DN;
  end
endmodule

// File: rtl/cyc_cfg_regs.sv
module cyc_cfg_regs #(
  parameter int unsigned VAL_W   = 20,
  parameter int unsigned MAX_VAL = 999999,
  parameter int unsigned DEF_VAL = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             pt_load_i,
  input  logic             wid_load_i,
  input  logic [VAL_W-1:0] load_val_i,
  output logic [VAL_W-1:0] pt_o,
  output logic [VAL_W-1:0] wid_o
);
  localparam logic [VAL_W-1:0] MaxV = VAL_W'(MAX_VAL);
  localparam logic [VAL_W-1:0] DefV = VAL_W'(DEF_VAL);

  logic [VAL_W-1:0] clamped;
  logic [VAL_W-1:0] pt_q, wid_q;

  assign clamped = (load_val_i > MaxV) ? MaxV : load_val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pt_q  <= DefV;
      wid_q <= DefV;
    end else if (init_i) begin
      pt_q  <= DefV;
      wid_q <= DefV;
    end else begin
      if (pt_load_i)  pt_q  <= clamped;
      if (wid_load_i) wid_q <= clamped;
    end
  end

  assign pt_o  = pt_q;
  assign wid_o = wid_q;
endmodule

// File: rtl/cyc_next.sv
module cyc_next
  import cyc_pkg::*;
#(
  parameter int unsigned VAL_W = 20
) (
  input  step_e            step_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic [VAL_W-1:0] pt_i,
  input  logic [VAL_W-1:0] wid_i,
  output logic [VAL_W-1:0] value_o,
  output logic             wrap_o,
  output logic             hit_o
);
  logic [VAL_W:0] inc;
  logic           wid_zero;

  assign inc      = {1'b0, value_i} + 1'b1;
  assign wid_zero = (wid_i == '0);

  always_comb begin
    value_o = value_i;
    wrap_o  = 1'b0;
    hit_o   = 1'b0;
    if (!wid_zero) begin
      unique case (step_i)
        STEP_UP: begin
          // point compares against the pre-wrap value so point == width is met
          hit_o = (inc == {1'b0, pt_i});
          if (inc >= {1'b0, wid_i}) begin
            value_o = '0;
            wrap_o  = 1'b1;
          end else begin
            value_o = inc[VAL_W-1:0];
          end
        end
        STEP_DN: begin
          if (value_i == '0) begin
            value_o = wid_i - 1'b1;
            wrap_o  = 1'b1;
          end else begin
            value_o = value_i - 1'b1;
          end
          hit_o = (value_o == pt_i);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cyc_coin.sv
module cyc_coin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic out_dis_i,
  input  logic hit_i,
  output logic coin_o
);
  logic coin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               coin_q <= 1'b0;
    else if (init_i || out_dis_i) coin_q <= 1'b0;
    else if (hit_i)            coin_q <= 1'b1;
  end

  assign coin_o = coin_q;
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter
  import cyc_pkg::*;
#(
  parameter int unsigned MAX_VAL = 999999,
  parameter int unsigned DEF_VAL = 100,
  localparam int unsigned VAL_W  = clog2_min1(MAX_VAL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             cnt_en_i,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic             sw_clr_i,
  input  logic             ext_clr_i,
  input  logic             pt_load_i,
  input  logic             wid_load_i,
  input  logic [VAL_W-1:0] load_val_i,
  input  logic             out_dis_i,
  output logic [VAL_W-1:0] value_o,
  output logic             coin_o,
  output logic             wrap_o
);
  step_e            step;
  logic [VAL_W-1:0] pt_q, width_q;
  logic [VAL_W-1:0] value_q, value_d;
  logic             wrap_q, wrap_d, hit, hit_ok, clr;

  assign clr = sw_clr_i | ext_clr_i;

  cyc_step_dec u_dec (
    .en_i  (cnt_en_i),
    .up_i  (cnt_up_i),
    .dn_i  (cnt_dn_i),
    .step_o(step)
  );

  cyc_cfg_regs #(
    .VAL_W  (VAL_W),
    .MAX_VAL(MAX_VAL),
    .DEF_VAL(DEF_VAL)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init_i),
    .pt_load_i (pt_load_i),
    .wid_load_i(wid_load_i),
    .load_val_i(load_val_i),
    .pt_o      (pt_q),
    .wid_o     (width_q)
  );

  cyc_next #(.VAL_W(VAL_W)) u_next (
    .step_i (step),
    .value_i(value_q),
    .pt_i   (pt_q),
    .wid_i  (width_q),
    .value_o(value_d),
    .wrap_o (wrap_d),
    .hit_o  (hit)
  );

  assign hit_ok = hit & ~init_i & ~clr;

  cyc_coin u_coin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (init_i),
    .out_dis_i(out_dis_i),
    .hit_i    (hit_ok),
    .coin_o   (coin_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
      wrap_q  <= 1'b0;
    end else if (init_i || clr) begin
      value_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      value_q <= value_d;
      wrap_q  <= wrap_d;
    end
  end

  assign value_o = value_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/cyc_counter_chk.sv
module cyc_counter_chk #(
  parameter int unsigned MAX_VAL = 999999,
  parameter int unsigned VAL_W   = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_i,
  input logic             cnt_en_i,
  input logic             cnt_up_i,
  input logic             cnt_dn_i,
  input logic             sw_clr_i,
  input logic             ext_clr_i,
  input logic             out_dis_i,
  input logic [VAL_W-1:0] width_q,
  input logic [VAL_W-1:0] value_o,
  input logic             coin_o,
  input logic             wrap_o
);
  logic up_step;
  assign up_step = cnt_en_i & cnt_up_i & ~cnt_dn_i;

  assert_up_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_step && !init_i && !sw_clr_i && !ext_clr_i && width_q != '0
      && ({1'b0, value_o} + 1'b1 >= {1'b0, width_q})
    |=> value_o == '0 && wrap_o);

  assert_clear_holds_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i || ext_clr_i) |=> value_o == '0 && !wrap_o);

  assert_clear_keeps_coin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i || ext_clr_i) && !init_i && !out_dis_i && coin_o |=> coin_o);

  assert_width_zero_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_q == '0 && !init_i && !sw_clr_i && !ext_clr_i
    |=> $stable(value_o) && !wrap_o);

  assert_out_dis_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_dis_i |=> !coin_o);

  assert_coin_needs_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !coin_o ##1 coin_o |-> $past(cnt_en_i && (cnt_up_i ^ cnt_dn_i)));

  assert_value_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    value_o <= VAL_W'(MAX_VAL));

  assert_init_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> value_o == '0 && !coin_o && !wrap_o);
endmodule

bind cyc_counter cyc_counter_chk #(.MAX_VAL(MAX_VAL), .VAL_W(VAL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .init_i   (init_i),
  .cnt_en_i (cnt_en_i),
  .cnt_up_i (cnt_up_i),
  .cnt_dn_i (cnt_dn_i),
  .sw_clr_i (sw_clr_i),
  .ext_clr_i(ext_clr_i),
  .out_dis_i(out_dis_i),
  .width_q  (width_q),
  .value_o  (value_o),
  .coin_o   (coin_o),
  .wrap_o   (wrap_o)
);

// File: tb/tb_cyc_counter.sv
`timescale 1ns/1ps
module tb_cyc_counter;
  localparam int VW = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic init_i = 0, cnt_en_i = 0, cnt_up_i = 0, cnt_dn_i = 0;
  logic sw_clr_i = 0, ext_clr_i = 0, pt_load_i = 0, wid_load_i = 0, out_dis_i = 0;
  logic [VW-1:0] load_val_i = '0;
  logic [VW-1:0] value_o;
  logic coin_o, wrap_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cyc_counter dut (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .cnt_en_i(cnt_en_i),
    .cnt_up_i(cnt_up_i), .cnt_dn_i(cnt_dn_i), .sw_clr_i(sw_clr_i),
    .ext_clr_i(ext_clr_i), .pt_load_i(pt_load_i), .wid_load_i(wid_load_i),
    .load_val_i(load_val_i), .out_dis_i(out_dis_i),
    .value_o(value_o), .coin_o(coin_o), .wrap_o(wrap_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // inputs change on the falling edge; result is read one falling edge later
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    init_i = 0; cnt_up_i = 0; cnt_dn_i = 0; pt_load_i = 0; wid_load_i = 0;
  endtask

  task automatic step(input bit up, input bit dn);
    cnt_up_i = up; cnt_dn_i = dn; tick();
  endtask

  task automatic setup(input int pt, input int wid);
    load_val_i = VW'(pt); pt_load_i = 1; tick();
    load_val_i = VW'(wid); wid_load_i = 1; tick();
    sw_clr_i = 1; tick(); sw_clr_i = 0;
    out_dis_i = 1; tick(); out_dis_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 value", int'(value_o), 0);
    chk("R1 coin", int'(coin_o), 0);
    chk("R1 wrap", int'(wrap_o), 0);
    cnt_en_i = 1;
    // defaults: point 100, width 100
    for (int k = 1; k <= 100; k++) begin
      step(1, 0);
      if (k == 99) begin
        chk("R1 value 99", int'(value_o), 99);
        chk("R1 coin before point", int'(coin_o), 0);
      end
    end
    chk("R1 R7 wrap at default width", int'(value_o), 0);
    chk("R1 R3 wrap pulse", int'(wrap_o), 1);
    chk("R1 R7 coin at default point", int'(coin_o), 1);
    step(0, 0);
    chk("R3 wrap one cycle", int'(wrap_o), 0);

    // up sweep
    for (int wid = 1; wid <= 6; wid++) begin
      for (int pt = 0; pt <= 6; pt++) begin
        setup(pt, wid);
        for (int k = 1; k <= 2 * wid + 1; k++) begin
          step(1, 0);
          chk("R2 R3 up value", int'(value_o), k % wid);
          chk("R3 up wrap", int'(wrap_o), int'(k % wid == 0));
          chk("R7 up coin", int'(coin_o), int'(pt >= 1 && pt <= wid && k >= pt));
        end
      end
    end

    // down sweep
    for (int wid = 1; wid <= 6; wid++) begin
      for (int pt = 0; pt <= 6; pt++) begin
        int k0;
        k0 = ((wid - pt) % wid == 0) ? wid : (wid - pt) % wid;
        setup(pt, wid);
        for (int k = 1; k <= 2 * wid + 1; k++) begin
          step(0, 1);
          chk("R4 down value", int'(value_o), (wid - (k % wid)) % wid);
          chk("R4 down wrap", int'(wrap_o), int'((k - 1) % wid == 0));
          chk("R7 down coin", int'(coin_o), int'(pt < wid && k >= k0));
        end
      end
    end

    // R2: enable low and both pulses
    setup(50, 10);
    step(1, 0); step(1, 0);
    cnt_en_i = 0; step(1, 0); step(0, 1);
    chk("R2 enable low", int'(value_o), 2);
    cnt_en_i = 1; step(1, 1);
    chk("R2 both pulses", int'(value_o), 2);

    // R9: load keeps value
    load_val_i = VW'(8); wid_load_i = 1; tick();
    chk("R9 load keeps value", int'(value_o), 2);

    // R5: width zero
    load_val_i = '0; wid_load_i = 1; tick();
    step(1, 0); step(0, 1); step(1, 0);
    chk("R5 width zero value", int'(value_o), 2);
    chk("R5 width zero wrap", int'(wrap_o), 0);

    // R6: clear keeps coin
    setup(2, 10);
    step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    chk("R6 pre coin", int'(coin_o), 1);
    sw_clr_i = 1; step(1, 0); step(1, 0);
    chk("R6 sw clear value", int'(value_o), 0);
    chk("R6 sw clear coin kept", int'(coin_o), 1);
    sw_clr_i = 0; ext_clr_i = 1; step(1, 0); step(0, 1);
    chk("R6 ext clear value", int'(value_o), 0);
    ext_clr_i = 0; step(1, 0);
    chk("R6 counts after clear", int'(value_o), 1);

    // R8: out_dis held
    out_dis_i = 1; step(1, 0); step(1, 0);
    chk("R8 coin off while disabled", int'(coin_o), 0);
    chk("R8 value", int'(value_o), 3);
    out_dis_i = 0; step(1, 0);
    chk("R8 coin stays off", int'(coin_o), 0);

    // R9: clamp width to MAX_VAL
    setup(5, 1048575);
    step(0, 1);
    chk("R9 clamped width", int'(value_o), 999998);
    chk("R9 clamp wrap", int'(wrap_o), 1);

    // R10: init
    setup(1, 10);
    step(1, 0);
    chk("R10 pre coin", int'(coin_o), 1);
    init_i = 1; sw_clr_i = 0; cnt_up_i = 1; load_val_i = VW'(7); wid_load_i = 1; tick();
    chk("R10 value", int'(value_o), 0);
    chk("R10 coin", int'(coin_o), 0);
    step(0, 1);
    chk("R10 width 100", int'(value_o), 99);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule